// File: doc/BRIEF.md
# Serial Flash Command Decoder

This block is the device-side receiver of a serial flash command stream. It sees chip select (active low), the serial clock and the serial data input as synchronous inputs in a faster system clock domain. On each serial-clock rising edge it shifts in one bit, most significant bit first, and groups the bits into bytes. The first byte of a frame is always the opcode. A small opcode table then says how many address bytes follow (none, three or four), whether a mode byte follows, and whether the command reads or writes.

Read commands go to the back end as a read request as soon as their header (opcode, address, optional mode byte) is complete. How the frame ends does not matter for a read. Write data bytes go out one strobe per byte, each tagged with its ascending byte address. A non-read command is committed only at the rise of chip select, and only if the frame held a whole, nonzero number of bytes covering at least its header. While the embedded-operation engine reports busy, only opcodes in a parameterised allow-list get through. Every other opcode is dropped without any output.

Top module: `sfe_cmd_front`

## Requirements
- R1: After reset, `cmd_vld_o`, `rd_req_o` and `data_vld_o` are low.
- R2: The first eight bits sampled on `sck_i` rising edges after `cs_ni` falls form the opcode, most significant bit first. A stand-alone opcode in an 8-clock frame is reported on `cmd_op_o` with a one-cycle `cmd_vld_o` after `cs_ni` rises.
- R3: A non-read frame whose clock count at the `cs_ni` rise is zero or not a multiple of 8 produces no `cmd_vld_o`.
- R4: Raising `cs_ni` discards any partial byte, so the next frame's opcode is decoded from its own first eight bits.
- R5: Opcodes 0x02 (program) and 0x20 (erase) take a 3-byte address, which appears on `cmd_addr_o` with the upper byte zero.
- R6: Opcodes 0x12 (program) and 0xDC (erase) take a 4-byte address.
- R7: Each write data byte after the header gives one `data_vld_o` pulse. `data_addr_o` equals the command address plus the byte's index, starting at 0.
- R8: Reads (0x03 with 3 address bytes, 0x13 with 4, 0xEB with 3 plus mode, 0x05 with none) give one `rd_req_o` pulse when the header completes. The pulse carries the address, and no `cmd_vld_o` follows, however the frame ends.
- R9: For 0xEB the byte after the address appears on `cmd_mode_o` with `rd_req_o`.
- R10: With `busy_i` high at the opcode byte, only opcodes in `OK_OPS` (default 0x05, 0x75) produce any strobe. All others produce no `cmd_vld_o`, `rd_req_o` or `data_vld_o`.
- R11: A non-read frame shorter than its header is rejected even on a byte boundary.
- R12: `cmd_len_o` gives the number of bytes after the header when `cmd_vld_o` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, synchronous |
| sck_i | input | 1 | Serial clock level, synchronous |
| si_i | input | 1 | Serial data in |
| busy_i | input | 1 | Embedded operation in progress |
| cmd_vld_o | output | 1 | Accepted non-read command strobe |
| cmd_op_o | output | 8 | Latched opcode |
| cmd_addr_o | output | 32 | Latched address |
| cmd_mode_o | output | 8 | Latched mode byte |
| cmd_len_o | output | BCNT_W | Data bytes in accepted command |
| rd_req_o | output | 1 | Read request strobe |
| data_vld_o | output | 1 | Write data byte strobe |
| data_o | output | 8 | Write data byte |
| data_addr_o | output | 32 | Address of write data byte |

## Verification
Two events can fall in the same system-clock cycle: the strobe for the last write data byte and the detection of the chip-select rise that commits the command. The bench raises `cs_ni` one system clock after the final serial-clock rising edge, while `sck_i` is still high, so both are handled together. The bench then requires a correct `cmd_len_o` in that same frame, a data strobe for the final byte and an accepted command. A second overlap is a one-byte stand-alone frame closed just as its opcode byte completes. There the acceptance has to use the opcode being decoded in that cycle, not the latched one.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  typedef enum logic [1:0] {
    ALEN_NONE = 2'd0,
    ALEN_24   = 2'd1,
    ALEN_32   = 2'd2
  } alen_e;

  typedef struct packed {
    alen_e alen;
    logic  has_mode;
    logic  is_rd;
    logic  is_wr;
  } op_attr_t;

  function automatic op_attr_t op_lookup(input logic [7:0] op);
    op_attr_t a;
    a = '{alen: ALEN_NONE, has_mode: 1'b0, is_rd: 1'b0, is_wr: 1'b0};
    unique case (op)
      8'h03: begin a.alen = ALEN_24; a.is_rd = 1'b1; end
      8'h13: begin a.alen = ALEN_32; a.is_rd = 1'b1; end
      8'hEB: begin a.alen = ALEN_24; a.is_rd = 1'b1; a.has_mode = 1'b1; end
      8'h05: a.is_rd = 1'b1;
      8'h02: begin a.alen = ALEN_24; a.is_wr = 1'b1; end
      8'h12: begin a.alen = ALEN_32; a.is_wr = 1'b1; end
      8'h20: a.alen = ALEN_24;
      8'hDC: a.alen = ALEN_32;
      default: ;
    endcase
    return a;
  endfunction

  function automatic logic [2:0] addr_bytes(input alen_e l);
    return (l == ALEN_24) ? 3'd3 : (l == ALEN_32) ? 3'd4 : 3'd0;
  endfunction

  function automatic logic [2:0] hdr_bytes(input op_attr_t a);
    return 3'd1 + addr_bytes(a.alen) + {2'b0, a.has_mode};
  endfunction

endpackage

// File: rtl/sfe_edge.sv
module sfe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  output logic sel_o,
  output logic sck_rise_o,
  output logic cs_rise_o
);
  logic sck_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
    end
  end

  assign sel_o      = !cs_ni;
  assign sck_rise_o = sck_i && !sck_q && !cs_ni;
  assign cs_rise_o  = cs_ni && !cs_q;
endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter #(
  parameter int unsigned BCNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              sck_rise_i,
  input  logic              si_i,
  output logic              byte_stb_o,
  output logic [7:0]        byte_o,
  output logic [2:0]        bit_idx_o,
  output logic [BCNT_W-1:0] byte_cnt_o
);
  localparam logic [BCNT_W-1:0] CNT_MAX = '1;

  logic [6:0]        sr_q;
  logic [2:0]        bit_idx_q;
  logic [BCNT_W-1:0] byte_cnt_q;
  logic              stb_q;
  logic [7:0]        byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= '0;
      bit_idx_q  <= '0;
      byte_cnt_q <= '0;
      stb_q      <= 1'b0;
      byte_q     <= '0;
    end else begin
      stb_q <= sck_rise_i && (bit_idx_q == 3'd7);
      if (!sel_i) begin
        bit_idx_q  <= '0;
        byte_cnt_q <= '0;
      end else if (sck_rise_i) begin
        sr_q      <= {sr_q[5:0], si_i};
        bit_idx_q <= bit_idx_q + 3'd1;
        if (bit_idx_q == 3'd7) begin
          byte_q <= {sr_q, si_i};
          if (byte_cnt_q != CNT_MAX) byte_cnt_q <= byte_cnt_q + 1'b1;
        end
      end
    end
  end

  assign byte_stb_o = stb_q;
  assign byte_o     = byte_q;
  assign bit_idx_o  = bit_idx_q;
  assign byte_cnt_o = byte_cnt_q;

  // deselect must leave no partial byte behind
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> (bit_idx_q == 3'd0) && (byte_cnt_q == '0));
endmodule

// File: rtl/sfe_op_table.sv
module sfe_op_table
  import sfe_pkg::*;
#(
  parameter int unsigned       N_OK   = 2,
  parameter logic [N_OK*8-1:0] OK_OPS = 16'h7505
) (
  input  logic [7:0] op_i,
  input  logic       busy_i,
  output op_attr_t   attr_o,
  output logic       allowed_o
);
  logic [N_OK-1:0] hit;

  for (genvar g = 0; g < N_OK; g++) begin : g_ok
    assign hit[g] = (op_i == OK_OPS[g*8 +: 8]);
  end

  assign attr_o    = op_lookup(op_i);
  assign allowed_o = !busy_i || (|hit);
endmodule

// File: rtl/sfe_cmd_front.sv
module sfe_cmd_front
  import sfe_pkg::*;
#(
  parameter int unsigned       BCNT_W = 16,
  parameter int unsigned       N_OK   = 2,
  parameter logic [N_OK*8-1:0] OK_OPS = 16'h7505
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              busy_i,
  output logic              cmd_vld_o,
  output logic [7:0]        cmd_op_o,
  output logic [31:0]       cmd_addr_o,
  output logic [7:0]        cmd_mode_o,
  output logic [BCNT_W-1:0] cmd_len_o,
  output logic              rd_req_o,
  output logic              data_vld_o,
  output logic [7:0]        data_o,
  output logic [31:0]       data_addr_o
);
  logic              sel, sck_rise, cs_rise;
  logic              byte_stb;
  logic [7:0]        byte_w;
  logic [2:0]        bit_idx;
  logic [BCNT_W-1:0] byte_cnt;
  op_attr_t          attr_w, attr_q, attr_c;
  logic              allowed_w, ok_q, ok_c, first_w;
  logic [BCNT_W-1:0] hdr_c, k_w, ab_w;

  logic [7:0]        op_q, mode_q, data_q;
  logic [31:0]       addr_q, data_addr_q;
  logic [BCNT_W-1:0] len_q;
  logic              cmd_vld_q, rd_req_q, data_vld_q;

  sfe_edge u_edge (
    .clk_i, .rst_ni, .cs_ni, .sck_i,
    .sel_o(sel), .sck_rise_o(sck_rise), .cs_rise_o(cs_rise)
  );

  sfe_shifter #(.BCNT_W(BCNT_W)) u_shift (
    .clk_i, .rst_ni, .sel_i(sel), .sck_rise_i(sck_rise), .si_i,
    .byte_stb_o(byte_stb), .byte_o(byte_w), .bit_idx_o(bit_idx), .byte_cnt_o(byte_cnt)
  );

  sfe_op_table #(.N_OK(N_OK), .OK_OPS(OK_OPS)) u_tab (
    .op_i(byte_w), .busy_i, .attr_o(attr_w), .allowed_o(allowed_w)
  );

  // opcode byte still in flight: use its decode, not the latched one
  assign first_w = byte_stb && (byte_cnt == BCNT_W'(1));
  assign attr_c  = first_w ? attr_w : attr_q;
  assign ok_c    = first_w ? allowed_w : ok_q;
  assign hdr_c   = BCNT_W'(hdr_bytes(attr_c));
  assign ab_w    = BCNT_W'(addr_bytes(attr_q.alen));
  assign k_w     = byte_cnt - BCNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q        <= '0;
      attr_q      <= '0;
      ok_q        <= 1'b0;
      addr_q      <= '0;
      mode_q      <= '0;
      data_q      <= '0;
      data_addr_q <= '0;
      len_q       <= '0;
      cmd_vld_q   <= 1'b0;
      rd_req_q    <= 1'b0;
      data_vld_q  <= 1'b0;
    end else begin
      cmd_vld_q  <= 1'b0;
      rd_req_q   <= 1'b0;
      data_vld_q <= 1'b0;
      if (byte_stb) begin
        if (first_w) begin
          op_q   <= byte_w;
          attr_q <= attr_w;
          ok_q   <= allowed_w;
          addr_q <= '0;
          mode_q <= '0;
        end else if (k_w <= ab_w) begin
          addr_q <= {addr_q[23:0], byte_w};
        end else if (attr_q.has_mode && (k_w == ab_w + BCNT_W'(1))) begin
          mode_q <= byte_w;
        end else if (attr_q.is_wr && ok_q) begin
          data_vld_q  <= 1'b1;
          data_q      <= byte_w;
          data_addr_q <= addr_q + 32'(k_w - hdr_c);
        end
        if (attr_c.is_rd && ok_c && (byte_cnt == hdr_c)) rd_req_q <= 1'b1;
      end
      if (cs_rise) begin
        cmd_vld_q <= (byte_cnt != '0) && (bit_idx == 3'd0) && !attr_c.is_rd
                     && ok_c && (byte_cnt >= hdr_c);
        len_q     <= byte_cnt - hdr_c;
      end
    end
  end

  assign cmd_vld_o   = cmd_vld_q;
  assign cmd_op_o    = op_q;
  assign cmd_addr_o  = addr_q;
  assign cmd_mode_o  = mode_q;
  assign cmd_len_o   = len_q;
  assign rd_req_o    = rd_req_q;
  assign data_vld_o  = data_vld_q;
  assign data_o      = data_q;
  assign data_addr_o = data_addr_q;

  p_cmd_after_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |-> $past(cs_ni));
  p_one_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_vld_o && rd_req_o));
  p_rd_in_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !$past(cs_ni, 2));
  p_busy_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_vld_o |-> ok_q);
endmodule

// File: tb/sfe_cmd_front_tb.sv
module sfe_cmd_front_tb_top;
  localparam int BW = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck = 1'b0, si = 1'b0, busy = 1'b0;
  logic cmd_vld, rd_req, data_vld;
  logic [7:0] cmd_op, cmd_mode, data;
  logic [31:0] cmd_addr, data_addr;
  logic [BW-1:0] cmd_len;

  always #2.5 clk = ~clk;

  sfe_cmd_front dut_i (
    .clk_i(clk), .rst_ni, .cs_ni, .sck_i(sck), .si_i(si), .busy_i(busy),
    .cmd_vld_o(cmd_vld), .cmd_op_o(cmd_op), .cmd_addr_o(cmd_addr),
    .cmd_mode_o(cmd_mode), .cmd_len_o(cmd_len), .rd_req_o(rd_req),
    .data_vld_o(data_vld), .data_o(data), .data_addr_o(data_addr)
  );

  int n_chk = 0, n_fail = 0;
  int n_cmd, n_rd, n_dat;
  logic [7:0] m_op, m_mode, r_mode;
  logic [31:0] m_addr, r_addr;
  logic [BW-1:0] m_len;
  logic [7:0] dat [16];
  logic [31:0] dad [16];

  always @(negedge clk) begin
    if (cmd_vld) begin n_cmd++; m_op = cmd_op; m_addr = cmd_addr; m_mode = cmd_mode; m_len = cmd_len; end
    if (rd_req) begin n_rd++; r_addr = cmd_addr; r_mode = cmd_mode; end
    if (data_vld && n_dat < 16) begin dat[n_dat] = data; dad[n_dat] = data_addr; n_dat++; end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input longint act, input longint exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clr();
    n_cmd = 0; n_rd = 0; n_dat = 0;
  endtask

  task automatic sel();
    cs_ni = 1'b0; tick(2);
  endtask

  task automatic one_bit(input logic b);
    si = b; tick(2); sck = 1'b1; tick(3); sck = 1'b0; tick(1);
  endtask

  task automatic bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) one_bit(v[i]);
  endtask

  task automatic desel();
    tick(2); cs_ni = 1'b1; tick(8);
  endtask

  // last bit rises, chip select rises one system clock later with sck still high
  task automatic last_bit_tight(input logic b);
    si = b; tick(2); sck = 1'b1; tick(1); cs_ni = 1'b1; tick(3); sck = 1'b0; tick(6);
  endtask

  task automatic t_reset();
    chk_eq("R1 cmd_vld", cmd_vld, 0);
    chk_eq("R1 rd_req", rd_req, 0);
    chk_eq("R1 data_vld", data_vld, 0);
  endtask

  task automatic t_standalone();
    clr(); sel(); bits(32'h06, 8); desel();
    chk_eq("R2 cmd count", n_cmd, 1);
    chk_eq("R2 opcode", m_op, 8'h06);
    chk_eq("R12 len", m_len, 0);
    // one-byte frame closed as its opcode byte completes
    clr(); sel(); bits(32'h3, 7); last_bit_tight(1'b1);
    chk_eq("R2 tight cmd count", n_cmd, 1);
    chk_eq("R2 tight opcode", m_op, 8'h07);
  endtask

  task automatic t_bad_len();
    clr(); sel(); bits(32'h06, 8); bits(32'h5, 3); desel();
    chk_eq("R3 11 clocks", n_cmd, 0);
    clr(); sel(); desel();
    chk_eq("R3 zero clocks", n_cmd, 0);
    clr(); sel(); bits(32'h75, 5); desel();
    chk_eq("R3 5 clocks", n_cmd, 0);
  endtask

  task automatic t_carry();
    clr(); sel(); bits(32'hA, 4); desel();
    sel(); bits(32'h06, 8); desel();
    chk_eq("R4 count", n_cmd, 1);
    chk_eq("R4 opcode", m_op, 8'h06);
  endtask

  task automatic t_prog24();
    clr(); sel(); bits(32'h02, 8); bits(32'h123456, 24);
    bits(32'hA5, 8); bits(32'h3C, 8); bits(32'h7E, 8); desel();
    chk_eq("R5 cmd", n_cmd, 1);
    chk_eq("R5 addr", m_addr, 32'h0012_3456);
    chk_eq("R12 len", m_len, 3);
    chk_eq("R7 data count", n_dat, 3);
    chk_eq("R7 byte0", dat[0], 8'hA5);
    chk_eq("R7 byte2", dat[2], 8'h7E);
    chk_eq("R7 addr0", dad[0], 32'h0012_3456);
    chk_eq("R7 addr1", dad[1], 32'h0012_3457);
    chk_eq("R7 addr2", dad[2], 32'h0012_3458);
  endtask

  task automatic t_prog32_tight();
    clr(); sel(); bits(32'h12, 8); bits(32'hFEDCBA98, 32);
    bits(32'h11, 8); bits(32'h22 >> 1, 7); last_bit_tight(1'b0);
    chk_eq("R6 cmd", n_cmd, 1);
    chk_eq("R6 addr", m_addr, 32'hFEDC_BA98);
    chk_eq("R12 tight len", m_len, 2);
    chk_eq("R7 tight count", n_dat, 2);
    chk_eq("R7 tight byte1", dat[1], 8'h22);
    chk_eq("R7 tight addr1", dad[1], 32'hFEDC_BA99);
  endtask

  task automatic t_read();
    clr(); sel(); bits(32'h03, 8); bits(32'h0ABCDE, 24); bits(32'h1F, 5); desel();
    chk_eq("R8 rd count", n_rd, 1);
    chk_eq("R8 rd addr", r_addr, 32'h000A_BCDE);
    chk_eq("R8 no cmd", n_cmd, 0);
    clr(); sel(); bits(32'h13, 8); bits(32'h89ABCDEF, 32); bits(32'h0, 16); desel();
    chk_eq("R8 rd32 count", n_rd, 1);
    chk_eq("R8 rd32 addr", r_addr, 32'h89AB_CDEF);
    chk_eq("R8 rd32 no cmd", n_cmd, 0);
  endtask

  task automatic t_mode();
    clr(); sel(); bits(32'hEB, 8); bits(32'h111111, 24); bits(32'h5A, 8); bits(32'h0, 12); desel();
    chk_eq("R9 rd count", n_rd, 1);
    chk_eq("R9 mode", r_mode, 8'h5A);
    chk_eq("R9 addr", r_addr, 32'h0011_1111);
  endtask

  task automatic t_hdr_short();
    clr(); sel(); bits(32'h20, 8); bits(32'h4455, 16); desel();
    chk_eq("R11 short erase", n_cmd, 0);
    clr(); sel(); bits(32'hDC, 8); bits(32'h01020304, 32); desel();
    chk_eq("R6 erase32 cmd", n_cmd, 1);
    chk_eq("R6 erase32 addr", m_addr, 32'h0102_0304);
    clr(); sel(); bits(32'h20, 8); bits(32'h445566, 24); desel();
    chk_eq("R5 erase24 cmd", n_cmd, 1);
    chk_eq("R5 erase24 addr", m_addr, 32'h0044_5566);
  endtask

  task automatic t_busy();
    busy = 1'b1;
    clr(); sel(); bits(32'h02, 8); bits(32'h000100, 24); bits(32'hEE, 8); desel();
    chk_eq("R10 prog dropped", n_cmd, 0);
    chk_eq("R10 data dropped", n_dat, 0);
    clr(); sel(); bits(32'h03, 8); bits(32'h000200, 24); bits(32'h0, 8); desel();
    chk_eq("R10 read dropped", n_rd, 0);
    clr(); sel(); bits(32'h05, 8); bits(32'h0, 8); desel();
    chk_eq("R10 status passes", n_rd, 1);
    clr(); sel(); bits(32'h75, 8); desel();
    chk_eq("R10 allowed cmd", n_cmd, 1);
    chk_eq("R10 allowed op", m_op, 8'h75);
    clr(); sel(); bits(32'h06, 8); desel();
    chk_eq("R10 other cmd dropped", n_cmd, 0);
    busy = 1'b0;
  endtask

  initial begin
    clr();
    tick(4);
    t_reset();
    rst_ni = 1'b1;
    tick(4);
    t_reset();
    t_standalone();
    t_bad_len();
    t_carry();
    t_prog24();
    t_prog32_tight();
    t_read();
    t_mode();
    t_hdr_short();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule